// File: doc/BRIEF.md
# Dual-Profile NCO Quadrature Upconverter

This block shifts a complex baseband stream up to a programmable carrier. A 26-bit phase accumulator advances by a frequency tuning word on every clock. The top 10 bits of the phase address a quarter-wave sine table, which yields 12-bit signed cosine and sine samples. A mixer combines these with the incoming I and Q samples and produces one saturated, registered, real 12-bit sample per clock. The carrier frequency is `word × f_clk / 2^26`.

The block holds two tuning words, one for each of two profiles. Each word is loaded through byte-wide writes on an 8-bit address/data port, and every byte takes effect on the clock edge that writes it. The active profile is the OR of a configuration bit and an external profile pin. Switching profiles changes only the phase increment: the accumulator keeps its phase, so the carrier has no phase step. Two modes change the output. Tone mode emits the bare carrier and ignores I/Q. Inversion mode flips the sign of the sine product so that the other sideband is produced.

The datapath runs without a controller. The accumulator, table register, product register and output register each advance on every clock.

Top module: `nuc_upconv`

## Requirements
- R1: While `rst_n` is low, `dout` is 0. After reset the phase is 0, both tuning words are 0 and all modes are off, so zero I/Q gives `dout` = 0.
- R2: The configuration register is at address 0x00: bit 0 is tone mode, bit 1 is inversion and bit 2 is the profile-select bit. Tuning-word bytes holding word bits [9:2], [17:10] and [25:18] are at 0x02–0x04 for profile 0 and at 0x05–0x07 for profile 1. A write changes its register at the writing edge, and the new word sets the phase step from the following edge.
- R3: Address 0x01 holds the low two bits of both words: bits [1:0] go to profile 0 and bits [3:2] go to profile 1.
- R4: Profile 1 is active when the select bit OR `profile_pin` is 1. Otherwise profile 0 is active.
- R5: On each clock the accumulator adds the active word modulo 2^26. A profile change keeps the accumulated phase.
- R6: With both modes off, the output is floor((I·cos − Q·sin) / 2048).
- R7: With inversion on, the output is floor((I·cos + Q·sin) / 2048).
- R8: With tone mode on, the output equals the cosine sample and does not depend on I/Q.
- R9: Mixer results above 2047 give 2047, and results below −2048 give −2048.
- R10: I/Q, the mode bits and the phase sampled at edge E set `dout` after edge E+2. That is three register stages: capture, product, output.
- R11: For table phase p, sin = round(2047·sin(2π(p+0.5)/1024)), and cos takes the sin value at phase p+256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| profile_pin | input | 1 | External profile select, ORed with the register bit |
| i_in | input | 12 | In-phase sample, signed |
| q_in | input | 12 | Quadrature sample, signed |
| dout | output | 12 | Modulated output sample, signed |

## Verification
A register write lands at the edge that carries it. The phase step it implies applies from the next edge. An output sample appears two edges after the edge that captured its I/Q, its mode bits and its phase. The bench keeps its own accumulator and register image and computes the expected sample before each edge, with the model state that edge will see. It stores the value in a four-entry ring, then compares it against `dout` at the falling edge three edges later, so every comparison lands mid-cycle in the cycle the result is due. The cosine and sine values come from real-valued trigonometry, and comparisons allow ±2 LSB for table rounding.

// File: rtl/nuc_pkg.sv
package nuc_pkg;
    localparam int FTW_W  = 26;   // tuning word / accumulator width
    localparam int PH_W   = 10;   // table phase width
    localparam int SMP_W  = 12;   // sample width
    localparam int AW     = 8;
    localparam int DW     = 8;

    // register addresses
    localparam int A_CFG  = 0;
    localparam int A_LSB  = 1;
    localparam int A_P0   = 2;    // first high byte of profile 0
    localparam int A_P1   = 5;    // first high byte of profile 1

    typedef struct packed {
        logic sel;   // bit 2
        logic inv;   // bit 1
        logic tone;  // bit 0
    } cfg_t;
endpackage

// File: rtl/nuc_regs.sv
module nuc_regs
    import nuc_pkg::*;
#(
    parameter int P_FTW_W = FTW_W,
    parameter int P_AW    = AW,
    parameter int P_DW    = DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [P_AW-1:0]    wr_addr,
    input  logic [P_DW-1:0]    wr_data,
    input  logic               profile_pin,
    output cfg_t               cfg,
    output logic [P_FTW_W-1:0] ftw0,
    output logic [P_FTW_W-1:0] ftw1,
    output logic [P_FTW_W-1:0] ftw_act
);
    localparam int HI_W = P_FTW_W - 2;
    localparam int NB   = HI_W / P_DW;

    logic [1:0]      lsb0, lsb1;
    logic [HI_W-1:0] hi0, hi1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg  <= '0;
            lsb0 <= '0;
            lsb1 <= '0;
            hi0  <= '0;
            hi1  <= '0;
        end else if (wr_en) begin
            if (wr_addr == P_AW'(A_CFG)) cfg <= cfg_t'(wr_data[2:0]);
            if (wr_addr == P_AW'(A_LSB)) begin
                lsb0 <= wr_data[1:0];
                lsb1 <= wr_data[3:2];
            end
            for (int b = 0; b < NB; b++) begin
                if (wr_addr == P_AW'(A_P0 + b)) hi0[b*P_DW +: P_DW] <= wr_data;
                if (wr_addr == P_AW'(A_P1 + b)) hi1[b*P_DW +: P_DW] <= wr_data;
            end
        end
    end

    assign ftw0    = {hi0, lsb0};
    assign ftw1    = {hi1, lsb1};
    assign ftw_act = (cfg.sel | profile_pin) ? ftw1 : ftw0;
endmodule

// File: rtl/nuc_phase_acc.sv
module nuc_phase_acc #(
    parameter int P_FTW_W = 26,
    parameter int P_PH_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [P_FTW_W-1:0] step,
    output logic [P_PH_W-1:0]  phase
);
    logic [P_FTW_W-1:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc <= '0;
        else        acc <= acc + step;
    end

    assign phase = acc[P_FTW_W-1 -: P_PH_W];
endmodule

// File: rtl/nuc_sincos.sv
module nuc_sincos #(
    parameter int P_PH_W  = 10,
    parameter int P_SMP_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [P_PH_W-1:0]         phase,
    output logic signed [P_SMP_W-1:0] cos_q,
    output logic signed [P_SMP_W-1:0] sin_q
);
    localparam int QTR_W = P_PH_W - 2;
    localparam int QN    = 1 << QTR_W;
    localparam longint AMP        = (longint'(1) << (P_SMP_W - 1)) - 1;
    localparam longint HALF_PI_Q30 = 64'd1686629713;

    // sine at (k + 0.5) / QN of a quarter turn, Taylor series in Q30
    function automatic logic [P_SMP_W-2:0] qsin(input int k);
        longint x, x2, t, s;
        x  = (longint'(2 * k + 1) * HALF_PI_Q30) / longint'(2 * QN);
        x2 = (x * x) >>> 30;
        t  = x;
        s  = x;
        t  = ((t * x2) >>> 30) / 6;  s = s - t;
        t  = ((t * x2) >>> 30) / 20; s = s + t;
        t  = ((t * x2) >>> 30) / 42; s = s - t;
        t  = ((t * x2) >>> 30) / 72; s = s + t;
        return (P_SMP_W-1)'((s * AMP + (longint'(1) << 29)) >>> 30);
    endfunction

    logic [P_SMP_W-2:0] tbl [QN];

    for (genvar g = 0; g < QN; g++) begin : g_tbl
        localparam logic [P_SMP_W-2:0] V = qsin(g);
        assign tbl[g] = V;
    end

    function automatic logic signed [P_SMP_W-1:0] pick(input logic [P_PH_W-1:0] p);
        logic [QTR_W-1:0]          idx;
        logic signed [P_SMP_W-1:0] mag;
        idx = p[P_PH_W-2] ? ~p[QTR_W-1:0] : p[QTR_W-1:0];
        mag = {1'b0, tbl[idx]};
        return p[P_PH_W-1] ? -mag : mag;
    endfunction

    logic [P_PH_W-1:0] cphase;
    assign cphase = phase + P_PH_W'(QN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cos_q <= '0;
            sin_q <= '0;
        end else begin
            cos_q <= pick(cphase);
            sin_q <= pick(phase);
        end
    end
endmodule

// File: rtl/nuc_mixer.sv
module nuc_mixer #(
    parameter int P_SMP_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic signed [P_SMP_W-1:0] i_a,
    input  logic signed [P_SMP_W-1:0] q_a,
    input  logic signed [P_SMP_W-1:0] cos_a,
    input  logic signed [P_SMP_W-1:0] sin_a,
    input  logic                      tone_a,
    input  logic                      inv_a,
    output logic signed [P_SMP_W-1:0] dout
);
    localparam int PW = 2 * P_SMP_W;
    localparam logic signed [PW:0] MAXV = (PW+1)'((1 << (P_SMP_W - 1)) - 1);
    localparam logic signed [PW:0] MINV = -MAXV - 1;

    logic signed [PW-1:0]      ic_b, qs_b;
    logic signed [P_SMP_W-1:0] cos_b;
    logic                      tone_b, inv_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ic_b   <= '0;
            qs_b   <= '0;
            cos_b  <= '0;
            tone_b <= 1'b0;
            inv_b  <= 1'b0;
        end else begin
            ic_b   <= i_a * cos_a;
            qs_b   <= q_a * sin_a;
            cos_b  <= cos_a;
            tone_b <= tone_a;
            inv_b  <= inv_a;
        end
    end

    logic signed [PW:0]        sum, scl;
    logic signed [P_SMP_W-1:0] sat;

    always_comb begin
        sum = inv_b ? (PW+1)'(ic_b) + (PW+1)'(qs_b) : (PW+1)'(ic_b) - (PW+1)'(qs_b);
        scl = sum >>> (P_SMP_W - 1);
        if (scl > MAXV)      sat = MAXV[P_SMP_W-1:0];
        else if (scl < MINV) sat = MINV[P_SMP_W-1:0];
        else                 sat = scl[P_SMP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout <= '0;
        else        dout <= tone_b ? cos_b : sat;
    end
endmodule

// File: rtl/nuc_upconv.sv
module nuc_upconv
    import nuc_pkg::*;
#(
    parameter int P_FTW_W = FTW_W,
    parameter int P_PH_W  = PH_W,
    parameter int P_SMP_W = SMP_W,
    parameter int P_AW    = AW,
    parameter int P_DW    = DW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [P_AW-1:0]           wr_addr,
    input  logic [P_DW-1:0]           wr_data,
    input  logic                      profile_pin,
    input  logic signed [P_SMP_W-1:0] i_in,
    input  logic signed [P_SMP_W-1:0] q_in,
    output logic signed [P_SMP_W-1:0] dout
);
    cfg_t                      cfg;
    logic [P_FTW_W-1:0]        ftw0, ftw1, ftw_act;
    logic [P_PH_W-1:0]         phase;
    logic signed [P_SMP_W-1:0] cos_a, sin_a, i_a, q_a;
    logic                      tone_a, inv_a;

    nuc_regs #(.P_FTW_W(P_FTW_W), .P_AW(P_AW), .P_DW(P_DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .profile_pin(profile_pin), .cfg(cfg),
        .ftw0(ftw0), .ftw1(ftw1), .ftw_act(ftw_act)
    );

    nuc_phase_acc #(.P_FTW_W(P_FTW_W), .P_PH_W(P_PH_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .step(ftw_act), .phase(phase)
    );

    nuc_sincos #(.P_PH_W(P_PH_W), .P_SMP_W(P_SMP_W)) u_lut (
        .clk(clk), .rst_n(rst_n), .phase(phase), .cos_q(cos_a), .sin_q(sin_a)
    );

    // capture stage, aligned with the table register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_a    <= '0;
            q_a    <= '0;
            tone_a <= 1'b0;
            inv_a  <= 1'b0;
        end else begin
            i_a    <= i_in;
            q_a    <= q_in;
            tone_a <= cfg.tone;
            inv_a  <= cfg.inv;
        end
    end

    nuc_mixer #(.P_SMP_W(P_SMP_W)) u_mix (
        .clk(clk), .rst_n(rst_n), .i_a(i_a), .q_a(q_a), .cos_a(cos_a),
        .sin_a(sin_a), .tone_a(tone_a), .inv_a(inv_a), .dout(dout)
    );
endmodule

// File: rtl/nuc_upconv_chk.sv
module nuc_upconv_chk #(
    parameter int P_SMP_W = 12,
    parameter int P_AW    = 8,
    parameter int P_DW    = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [P_AW-1:0]           wr_addr,
    input logic [P_DW-1:0]           wr_data,
    input logic [2:0]                cfg_bits,
    input logic [1:0]                lo0,
    input logic [1:0]                lo1,
    input logic signed [P_SMP_W-1:0] i_a,
    input logic signed [P_SMP_W-1:0] q_a,
    input logic signed [P_SMP_W-1:0] cos_a,
    input logic signed [P_SMP_W-1:0] sin_a,
    input logic                      tone_a,
    input logic                      inv_a,
    input logic signed [P_SMP_W-1:0] dout
);
    localparam int PW = 2 * P_SMP_W;
    localparam logic signed [PW:0] HI = (PW+1)'((1 << (P_SMP_W - 1)) - 1);
    localparam logic signed [PW:0] LO = -HI - 1;

    logic signed [PW:0] ic, qs, mixed;
    logic               over_hi, over_lo;
    always_comb begin
        ic      = (PW+1)'(i_a * cos_a);
        qs      = (PW+1)'(q_a * sin_a);
        mixed   = (inv_a ? ic + qs : ic - qs) >>> (P_SMP_W - 1);
        over_hi = !tone_a && (mixed > HI);
        over_lo = !tone_a && (mixed < LO);
    end

    // R1
    rst_out_chk: assert property (@(posedge clk) !rst_n |-> dout == '0);

    // R2
    cfg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == P_AW'(0)) |=> cfg_bits == $past(wr_data[2:0]));

    // R3
    lsb_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == P_AW'(1)) |=> (lo0 == $past(wr_data[1:0]) && lo1 == $past(wr_data[3:2])));

    // R8
    tone_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tone_a, 2) |-> dout == $past(cos_a, 2));

    // R9
    sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(over_hi, 2) |-> dout == HI[P_SMP_W-1:0]);

    // R9
    sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(over_lo, 2) |-> dout == LO[P_SMP_W-1:0]);
endmodule

bind nuc_upconv nuc_upconv_chk #(.P_SMP_W(P_SMP_W), .P_AW(P_AW), .P_DW(P_DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_bits(cfg), .lo0(ftw0[1:0]), .lo1(ftw1[1:0]), .i_a(i_a), .q_a(q_a),
    .cos_a(cos_a), .sin_a(sin_a), .tone_a(tone_a), .inv_a(inv_a), .dout(dout)
);

// File: tb/nuc_upconv_tb.sv
`timescale 1ns/1ps
module nuc_upconv_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              profile_pin = 1'b0;
    logic signed [11:0] i_in = '0;
    logic signed [11:0] q_in = '0;
    logic signed [11:0] dout;

    always #2 clk = ~clk;   // 250 MHz

    nuc_upconv u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .profile_pin(profile_pin), .i_in(i_in),
        .q_in(q_in), .dout(dout)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench image of the block
    logic [2:0]  m_cfg  = '0;
    logic [25:0] m_ftw0 = '0;
    logic [25:0] m_ftw1 = '0;
    logic [25:0] m_acc  = '0;
    int          cyc    = 0;
    int          exp_q [4];
    string       tag_q [4];

    function automatic int lsin(int p);
        real a;
        a = 2.0 * 3.14159265358979 * (real'(p) + 0.5) / 1024.0;
        return int'(2047.0 * $sin(a));
    endfunction

    function automatic int model(logic [25:0] acc, int iv, int qv, logic tone, logic inv);
        int p, c, s, v;
        p = int'(acc[25:16]);
        c = lsin((p + 256) % 1024);
        s = lsin(p);
        if (tone) return c;
        v = iv * c + (inv ? qv * s : -(qv * s));
        v = v >>> 11;
        if (v > 2047)  v = 2047;
        if (v < -2048) v = -2048;
        return v;
    endfunction

    task automatic chk(int got, int exp, string tag);
        int d;
        n_vec++;
        d = got - exp;
        if (d > 2 || d < -2) begin
            n_bad++;
            $display("FAIL %s: dout=%0d expected=%0d (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    // one clock: predict, step the model, advance, compare the sample due now
    task automatic tick(string tag);
        int a;
        exp_q[cyc % 4] = model(m_acc, int'(i_in), int'(q_in), m_cfg[0], m_cfg[1]);
        tag_q[cyc % 4] = tag;
        m_acc = m_acc + ((m_cfg[2] | profile_pin) ? m_ftw1 : m_ftw0);
        if (wr_en) begin
            a = int'(wr_addr);
            if (a == 0) m_cfg = wr_data[2:0];
            if (a == 1) begin
                m_ftw0[1:0] = wr_data[1:0];
                m_ftw1[1:0] = wr_data[3:2];
            end
            if (a >= 2 && a <= 4) m_ftw0[2 + 8*(a-2) +: 8] = wr_data;
            if (a >= 5 && a <= 7) m_ftw1[2 + 8*(a-5) +: 8] = wr_data;
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
        if (cyc >= 3) chk(int'(dout), exp_q[(cyc - 3) % 4], tag_q[(cyc - 3) % 4]);
    endtask

    task automatic wr(int a, int d, string tag);
        wr_en   = 1'b1;
        wr_addr = 8'(a);
        wr_data = 8'(d);
        tick(tag);
        wr_en   = 1'b0;
    endtask

    task automatic run(int n, string tag, bit rnd);
        for (int k = 0; k < n; k++) begin
            if (rnd) begin
                i_in = 12'($urandom);
                q_in = 12'($urandom);
            end
            tick(tag);
        end
    endtask

    task automatic grid(string tag);
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                i_in = 12'(-2048 + a * 273);
                q_in = 12'(-2048 + b * 271);
                tick(tag);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: output held at zero in reset
        repeat (3) @(negedge clk);
        n_vec++;
        if (dout !== 12'sd0) begin
            n_bad++;
            $display("FAIL R1: dout=%0d expected=0 in reset", dout);
        end
        rst_n = 1'b1;
        run(8, "R1", 1'b0);

        // R11 R8: tone mode, one table step per clock, random I/Q ignored
        wr(0, 1, "R2");
        wr(3, 8'h40, "R2");
        run(1100, "R11 R8", 1'b1);

        // R2 R3: all bytes of profile 0, written while running
        wr(1, 8'h0B, "R3");
        wr(2, 8'hA5, "R2");
        wr(3, 8'h3C, "R2");
        wr(4, 8'h1F, "R2");
        run(300, "R2 R3", 1'b1);
        wr(4, 8'h07, "R2");
        run(200, "R2", 1'b1);

        // R4 R5: profile 1 by bit, then by pin; phase continues
        wr(5, 8'h11, "R4");
        wr(6, 8'h80, "R4");
        wr(7, 8'h02, "R4");
        wr(0, 5, "R4");
        run(200, "R4 R5", 1'b0);
        wr(0, 1, "R4");
        run(100, "R4 R5", 1'b0);
        profile_pin = 1'b1;
        run(200, "R4 R5", 1'b0);
        profile_pin = 1'b0;
        run(100, "R4 R5", 1'b0);

        // R6: plain modulation over an I/Q grid
        wr(0, 0, "R6");
        grid("R6");
        // R7: inverted sideband
        wr(0, 2, "R7");
        grid("R7");

        // R9: positive then negative saturation
        wr(0, 0, "R9");
        i_in = 12'sd2047; q_in = -12'sd2048;
        run(600, "R9", 1'b0);
        i_in = -12'sd2048; q_in = 12'sd2047;
        run(600, "R9", 1'b0);

        // R10: frozen phase, new I/Q each clock exposes the alignment
        wr(1, 0, "R10");
        wr(2, 0, "R10");
        wr(3, 0, "R10");
        wr(4, 0, "R10");
        run(300, "R10", 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule